// File: doc/BRIEF.md
# Phase-Adjustable Sine Reference Generator

This block supplies the sinusoidal reference that a multilevel PWM modulator compares against its carrier. One fundamental period is held as 60 signed samples. A programmable clock divider sets the rate at which the generator steps through those samples. Each sample is multiplied by an unsigned amplitude word, so that word sets the modulation index.

The generator is locked to the grid. Every rising edge of the grid reference input restarts the table. A signed phase command moves that restart point by a whole number of sample steps, which lets the control loop make the injected current lead or lag the supply voltage. The output carries the scaled sample, a one-cycle strobe for each new sample, and a flag that marks the positive half cycle.

A second lookup returns the phase that lags by 120 degrees. A third phase is not stored: it is derived as the saturated negative of the sum of the first two. A parameter removes both extra phases.

Top module: `sine_ref_gen`

## Requirements
- R1: While reset is held, and in the first cycles after it is released, ref_a, ref_b and ref_c are 0, ref_valid is low and pos_half is high. The table index is 0 and the divider count is 0.
- R2: When no restart occurs, ref_valid pulses for one cycle every tick_div+1 clock cycles. No strobe appears between two pulses.
- R3: Each strobe advances the table index k by one. The index wraps from 59 to 0, so one period is 60 samples.
- R4: ref_a equals round(T(k)·amp / 2^(AW+16−W)), with rounding half up. T(k) = round(32767·sin(2πk/60)). When amp is 0, every output is 0.
- R5: On the clock edge that first samples grid_ref high after it was low, the index is loaded with (−cmd) mod 60 and the divider restarts. The new sample, with its strobe, appears after that edge. A positive cmd delays the zero of the sine by cmd steps. A negative cmd advances it.
- R6: phase_cmd is a two's-complement count of sample steps. It is clamped to the range −30..+30 before use, so +100 and −100 both load index 30.
- R7: pos_half is high exactly while the current index is in 0..29.
- R8: ref_b is the sample at index (k+40) mod 60, which lags ref_a by 120 degrees. ref_c = −(ref_a+ref_b), saturated to W bits.
- R9: Holding grid_ref high without a new rising edge has no effect: samples keep stepping without a restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_div | input | DW | Sample period minus one, in clock cycles |
| amp | input | AW | Unsigned amplitude multiplicand, full scale 2^AW |
| grid_ref | input | 1 | Grid polarity reference; a rising edge restarts the table |
| phase_cmd | input | CW | Signed phase shift in sample steps |
| ref_a | output | W | Scaled reference sample, first phase |
| ref_b | output | W | Scaled reference sample, 120 degrees lagging phase |
| ref_c | output | W | Derived third phase |
| ref_valid | output | 1 | One-cycle strobe for a new sample |
| pos_half | output | 1 | High in the positive half of the period |

## Verification
Several properties are checked on every cycle:
- the index stays below 60;
- each strobe without a restart advances the index by one with wrap;
- a restart loads the clamped and negated command;
- no strobe appears before the divider expires;
- the sign of ref_a agrees with pos_half;
- the three phases sum to zero.

Other behaviour can only be shown by the bench's scenarios, which compare every strobed sample against a real-valued sine:
- the actual sample values and their scaling by amp;
- the 120-degree offset of ref_b;
- the clamping of large commands;
- a steady-high grid_ref causing no second restart.

// File: rtl/sine_ref_gen.sv
module sine_ref_gen #(
  parameter int W = 12,
  parameter int AW = 10,
  parameter int DW = 16,
  parameter int CW = 8,
  parameter bit THREE_PHASE = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DW-1:0]        tick_div,
  input  logic [AW-1:0]        amp,
  input  logic                 grid_ref,
  input  logic signed [CW-1:0] phase_cmd,
  output logic signed [W-1:0]  ref_a,
  output logic signed [W-1:0]  ref_b,
  output logic signed [W-1:0]  ref_c,
  output logic                 ref_valid,
  output logic                 pos_half
);
  localparam int N = 60;
  localparam int HALF = N / 2;
  localparam int IW = $clog2(N);
  localparam int SH = AW + 16 - W;
  localparam int PW = AW + 17;

  function automatic logic signed [15:0] sine_at(input int k);
    int r, q;
    logic signed [15:0] v;
    r = (k >= HALF) ? k - HALF : k;
    q = (r > 15) ? HALF - r : r;
    case (q)
      0: v = 16'sd0;       1: v = 16'sd3425;    2: v = 16'sd6813;    3: v = 16'sd10126;
      4: v = 16'sd13328;   5: v = 16'sd16384;   6: v = 16'sd19260;   7: v = 16'sd21925;
      8: v = 16'sd24351;   9: v = 16'sd26509;   10: v = 16'sd28377;  11: v = 16'sd29934;
      12: v = 16'sd31163;  13: v = 16'sd32051;  14: v = 16'sd32587;  default: v = 16'sd32767;
    endcase
    return (k >= HALF) ? -v : v;
  endfunction

  function automatic logic signed [W-1:0] scale(input logic signed [15:0] s, input logic [AW-1:0] g);
    logic signed [PW-1:0] p;
    p = PW'(s) * PW'($signed({1'b0, g}));
    p = p + (PW'(1) <<< (SH - 1));
    return W'(p >>> SH);
  endfunction

  logic [DW-1:0] cnt;
  logic [IW-1:0] idx, nidx, load;
  logic grid_q;
  logic signed [W-1:0] a_n, b_n, c_n;
  logic signed [W+1:0] neg_sum;

  wire rise = grid_ref & ~grid_q;
  wire tick = cnt >= tick_div;

  always_comb begin
    int ci, ki;
    ci = int'(phase_cmd);
    if (ci > HALF) ci = HALF;
    if (ci < -HALF) ci = -HALF;
    load = IW'((ci > 0) ? N - ci : -ci);
    nidx = rise ? load : ((idx == IW'(N - 1)) ? '0 : idx + 1'b1);
    ki = int'(nidx);
    a_n = scale(sine_at(ki), amp);
    b_n = scale(sine_at((ki >= 20) ? ki - 20 : ki + 40), amp);
    neg_sum = -((W+2)'(a_n) + (W+2)'(b_n));
    if (neg_sum > (W+2)'(2**(W-1) - 1)) c_n = {1'b0, {(W-1){1'b1}}};
    else if (neg_sum < -(W+2)'(2**(W-1))) c_n = {1'b1, {(W-1){1'b0}}};
    else c_n = W'(neg_sum);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      idx <= '0;
      grid_q <= 1'b0;
      ref_valid <= 1'b0;
      ref_a <= '0;
      ref_b <= '0;
      ref_c <= '0;
    end else begin
      grid_q <= grid_ref;
      ref_valid <= rise | tick;
      if (rise | tick) begin
        cnt <= '0;
        idx <= nidx;
        ref_a <= a_n;
        ref_b <= THREE_PHASE ? b_n : '0;
        ref_c <= THREE_PHASE ? c_n : '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign pos_half = idx < IW'(HALF);

  assert_idx_range_R3: assert property (@(posedge clk) disable iff (!rst_n) idx < IW'(N));

  assert_step_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_valid && !$past(rise)) |-> (idx == (($past(idx) == IW'(N - 1)) ? '0 : $past(idx) + 1'b1)));

  assert_resync_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rise) |-> (ref_valid && idx == $past(load)));

  assert_no_early_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(rise) && $past(cnt < tick_div)) |-> !ref_valid);

  assert_polarity_sign_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pos_half ? !ref_a[W-1] : (ref_a <= 0));

  assert_phase_sum_R8: assert property (@(posedge clk) disable iff (!rst_n)
    THREE_PHASE |-> ((W+2)'(ref_a) + (W+2)'(ref_b) + (W+2)'(ref_c) == '0));
endmodule

// File: tb/sine_ref_gen_tb.sv
module sine_ref_gen_tb_top;
  localparam int W = 12, AW = 10, DW = 16, CW = 8;
  localparam int SH = AW + 16 - W;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic [DW-1:0] tick_div = 16'd3;
  logic [AW-1:0] amp = '0;
  logic grid_ref = 1'b0;
  logic signed [CW-1:0] phase_cmd = '0;
  logic signed [W-1:0] ref_a, ref_b, ref_c;
  logic ref_valid, pos_half;

  sine_ref_gen #(.W(W), .AW(AW), .DW(DW), .CW(CW), .THREE_PHASE(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_div(tick_div), .amp(amp), .grid_ref(grid_ref),
    .phase_cmd(phase_cmd), .ref_a(ref_a), .ref_b(ref_b), .ref_c(ref_c),
    .ref_valid(ref_valid), .pos_half(pos_half));

  int checks = 0, failures = 0;
  int q_idx[$];
  int q_amp[$];
  bit mon_on = 1'b0;
  int period = 0;
  int cyc = 0;
  int last_cyc = -1;

  always @(posedge clk) cyc++;

  function automatic int rnd(real x);
    return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
  endfunction

  function automatic real ideal(int k, int a);
    return $sin(6.283185307179586 * real'(k) / 60.0) * 32767.0 * real'(a) / (2.0 ** SH);
  endfunction

  task automatic check(string req, string what, int act, int exp, int tol);
    int d;
    checks++;
    d = act - exp;
    if (d < 0) d = -d;
    if (d > tol) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Monitor: pops one expected item for every strobed sample.
  always @(negedge clk) begin
    if (mon_on && ref_valid) begin
      if (q_idx.size() == 0) begin
        check("R3", "unexpected sample", 1, 0, 0);
      end else begin
        int k, a, kb;
        k = q_idx.pop_front();
        a = q_amp.pop_front();
        kb = (k + 40) % 60;
        check("R4", "ref_a", int'(ref_a), rnd(ideal(k, a)), 1);
        check("R8", "ref_b", int'(ref_b), rnd(ideal(kb, a)), 1);
        check("R8", "ref_c", int'(ref_c), rnd(-(ideal(k, a) + ideal(kb, a))), 2);
        check("R7", "pos_half", int'(pos_half), (k < 30) ? 1 : 0, 0);
        if (last_cyc >= 0) check("R2", "strobe spacing", cyc - last_cyc, period, 0);
        last_cyc = cyc;
      end
    end
  end

  // Driver: restart with a command and queue the expected index sequence.
  task automatic run(int div, int a, int cmd, int n);
    int c, start;
    c = (cmd > 30) ? 30 : (cmd < -30) ? -30 : cmd;
    start = (c > 0) ? 60 - c : -c;
    @(posedge clk); #2;
    tick_div = DW'(div);
    amp = AW'(a);
    phase_cmd = CW'(cmd);
    grid_ref = 1'b0;
    @(posedge clk); #2;
    @(posedge clk); #2;
    for (int i = 0; i < n; i++) begin
      q_idx.push_back((start + i) % 60);
      q_amp.push_back(a);
    end
    period = div + 1;
    last_cyc = -1;
    grid_ref = 1'b1;
    @(posedge clk); #2;
    mon_on = 1'b1;
    while (q_idx.size() != 0) @(negedge clk);
    @(posedge clk); #2;
    mon_on = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "valid in reset", int'(ref_valid), 0, 0);
    check("R1", "ref_a in reset", int'(ref_a), 0, 0);
    check("R1", "pos_half in reset", int'(pos_half), 1, 0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "valid after reset", int'(ref_valid), 0, 0);
    check("R1", "ref_c after reset", int'(ref_c), 0, 0);
    // R3 R9: full period plus wrap, grid_ref held high throughout
    run(3, 1023, 0, 65);
    // R5: delayed restart wraps from 55
    run(3, 512, 5, 10);
    // R5: advanced restart
    run(1, 300, -7, 8);
    // R6: clamp both directions
    run(2, 800, 100, 3);
    run(2, 800, -100, 3);
    // R4: zero amplitude
    run(2, 0, 0, 5);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog all-requirements actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule